// File: doc/BRIEF.md
# Port Interrupt and Control Register Block

This block holds the control, interrupt and link-error registers of one port of a storage host controller. Software reaches it over a simple word-addressed read/write bus. Control bits are changed through two write addresses: one sets bits and the other clears them. Reading the set address returns a status view that also carries a port-ready flag.

Twelve event pulses are latched into an interrupt status word. The low half of that word shows each event gated by its enable bit. Bits 16 upward show the same events ungated. Enable bits are changed through separate set and clear addresses, and every write to either address also loads a two-bit steering field. Status bits are cleared in one of two ways, chosen by a control bit: by writing ones, or by reading the status word.

Three 16-bit link error counters (decode, CRC, handshake) each have a threshold. When a counter reaches its threshold, the matching event bit is raised. The single interrupt output is the OR of all gated status bits.

Top module: `port_irq_regs`

## Requirements
- R1: After a synchronous active-low reset, the following are all 0: the control bits, the enables, the steering field, the status word, the counters, the thresholds and `irq_o`.
- R2: A write to word address 0 sets each control bit [15:0] whose data bit is 1. A write to address 1 clears each such bit. Data bits that are 0 leave their control bits unchanged. Control bits 0, 1 and 2 drive `port_rst_o`, `dev_rst_o` and `port_init_o`.
- R3: A read of address 0 returns the control bits in [15:0] and `port_ready_i` in bit 31. All other bits read 0.
- R4: A write to address 3 sets enable bits [11:0] for each data bit that is 1. A write to address 4 clears them. Both writes load data [31:30] into `steer_o`. A read of address 3 returns the steering field in [31:30] and the enables in [11:0].
- R5: A pulse on `evt_i[i]` latches raw status bit i. A read of address 2 returns raw bits in [27:16] and raw AND enable in [11:0].
- R6: `irq_o` is the OR of the gated status bits. It rises in the cycle after an enabled event, and it stays 0 for an event whose enable is 0.
- R7: With control bit 3 set, a write to address 2 clears raw bit i when data bit i or data bit 16+i is 1. In this mode a read does not clear.
- R8: With control bit 3 clear, a read of address 2 returns the current word and then clears all raw bits. In this mode a write to address 2 has no effect.
- R9: Counters at addresses 5, 7 and 9 (decode, CRC, handshake) count pulses on `link_err_i[0]`, `[1]` and `[2]`, hold at 0xFFFF, and are loaded by a write to their address.
- R10: Thresholds sit at addresses 6, 8 and 10. When a counter steps to a value equal to its non-zero threshold, event bit 8, 9 or 10 is raised for decode, CRC or handshake. A threshold of 0 never raises an event.
- R11: When an event sets a raw bit in the same cycle that a clear removes it, the event wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (needed for read-to-clear) |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| evt_i | input | 12 | Event pulses, one per status bit |
| link_err_i | input | 3 | Error pulses: decode, CRC, handshake |
| port_ready_i | input | 1 | Port-ready flag from the port logic |
| irq_o | output | 1 | Interrupt request |
| steer_o | output | 2 | Interrupt steering field |
| port_rst_o | output | 1 | Port reset request (control bit 0) |
| dev_rst_o | output | 1 | Device reset request (control bit 1) |
| port_init_o | output | 1 | Port initialize request (control bit 2) |

## Verification
The event path is driven three ways: with an enabled bit, with a disabled bit, and with several bits together. These show that the masked half, the raw half and the interrupt pin each follow the right term. Clearing is tried in both modes, using both halves of the write data and a clear that collides with a new event. This separates the write-clear, read-clear and priority paths. Each counter is stepped below, onto and past its threshold, and is also preloaded near saturation. This shows that an event fires exactly on the equality step, that a zero threshold fires nothing, and that the count holds at its ceiling.

// File: rtl/pirq_pkg.sv
// Package: shared constants for the port interrupt/control register block.
// Assumes a word-addressed bus with a 4-bit address.
package pirq_pkg;
    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 32;
    localparam int EVT_W       = 12;
    localparam int RAW_LSB     = 16;
    localparam int NUM_CNT     = 3;
    localparam int CNT_W       = 16;
    localparam int CTRL_W      = 16;
    localparam int EV_THR_BASE = 8;
    localparam int WOC_BIT     = 3;
    localparam int READY_BIT   = 31;
    localparam int STEER_LSB   = 30;

    localparam logic [ADDR_W-1:0] A_CTRL_SET = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTRL_CLR = 4'd1;
    localparam logic [ADDR_W-1:0] A_IRQ_STAT = 4'd2;
    localparam logic [ADDR_W-1:0] A_EN_SET   = 4'd3;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 4'd4;
    localparam int                A_CNT_BASE = 5;   // counter k at 5+2k, threshold at 6+2k
endpackage

// File: rtl/pirq_ctrl_reg.sv
// Module: control register with set and clear write ports.
// Assumes set_we and clr_we are never both high (they come from distinct addresses).
module pirq_ctrl_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ctrl_o
);
    // Purpose: OR in ones on a set write, mask out ones on a clear write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_o <= '0;
        else if (set_we) ctrl_o <= ctrl_o | wdata;
        else if (clr_we) ctrl_o <= ctrl_o & ~wdata;
    end
endmodule

// File: rtl/pirq_err_counter.sv
// Module: saturating link error counter with a programmable threshold.
// Assumes: a software load has priority over a counted pulse. hit_o is combinational
// and is high in the cycle whose step lands on a non-zero threshold.
module pirq_err_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         err_i,
    input  logic         cnt_we,
    input  logic         thr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] thr_o,
    output logic         hit_o
);
    localparam logic [W-1:0] MAXV = '1;

    logic         step;
    logic [W-1:0] cnt_inc;

    // Purpose: decide whether this cycle advances the count and whether that lands on the threshold.
    always_comb begin
        step    = err_i && !cnt_we && (cnt_o != MAXV);
        cnt_inc = cnt_o + 1'b1;
        hit_o   = step && (thr_o != '0) && (cnt_inc == thr_o);
    end

    // Purpose: hold the count; a software load wins over a counted pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_o <= '0;
        else if (cnt_we) cnt_o <= wdata;
        else if (step)   cnt_o <= cnt_inc;
    end

    // Purpose: hold the threshold written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      thr_o <= '0;
        else if (thr_we) thr_o <= wdata;
    end
endmodule

// File: rtl/pirq_status.sv
// Module: raw event latch, enable mask and steering field.
// Assumes the caller has already chosen the clear mask for the current clear mode.
// New events take priority over a clear in the same cycle.
module pirq_status #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_mask,
    input  logic         en_set_we,
    input  logic         en_clr_we,
    input  logic [N-1:0] en_wdata,
    input  logic [1:0]   steer_wdata,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] en_o,
    output logic [1:0]   steer_o
);
    // Purpose: latch events; apply the clear mask but never drop an arriving event.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_o <= '0;
        else        raw_o <= (raw_o & ~clr_mask) | evt_i;
    end

    // Purpose: update enables and steering on either enable write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o    <= '0;
            steer_o <= '0;
        end else if (en_set_we) begin
            en_o    <= en_o | en_wdata;
            steer_o <= steer_wdata;
        end else if (en_clr_we) begin
            en_o    <= en_o & ~en_wdata;
            steer_o <= steer_wdata;
        end
    end
endmodule

// File: rtl/port_irq_regs.sv
// Module: per-port control, interrupt and link error register block (top).
// Assumes single-cycle bus accesses and combinational read data. rd_en marks a real read,
// which matters for read-to-clear mode.
module port_irq_regs
    import pirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic [NUM_CNT-1:0] link_err_i,
    input  logic              port_ready_i,
    output logic              irq_o,
    output logic [1:0]        steer_o,
    output logic              port_rst_o,
    output logic              dev_rst_o,
    output logic              port_init_o
);
    logic [CTRL_W-1:0]  ctrl_q;
    logic [EVT_W-1:0]   raw_q, en_q, masked, clr_mask, evt_all, hit_vec;
    logic [CNT_W-1:0]   cnt_q [NUM_CNT];
    logic [CNT_W-1:0]   thr_q [NUM_CNT];
    logic [NUM_CNT-1:0] hit;
    logic               stat_wr, stat_rd, woc;

    pirq_ctrl_reg #(.W(CTRL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .set_we(wr_en && addr == A_CTRL_SET),
        .clr_we(wr_en && addr == A_CTRL_CLR),
        .wdata(wdata[CTRL_W-1:0]),
        .ctrl_o(ctrl_q)
    );

    // Three counters; counter k sits at A_CNT_BASE+2k, its threshold one word above.
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        pirq_err_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .err_i(link_err_i[k]),
            .cnt_we(wr_en && addr == ADDR_W'(A_CNT_BASE + 2*k)),
            .thr_we(wr_en && addr == ADDR_W'(A_CNT_BASE + 2*k + 1)),
            .wdata(wdata[CNT_W-1:0]),
            .cnt_o(cnt_q[k]),
            .thr_o(thr_q[k]),
            .hit_o(hit[k])
        );
    end

    // Purpose: merge the counter threshold hits into the event vector and pick the clear mask.
    always_comb begin
        woc      = ctrl_q[WOC_BIT];
        stat_wr  = wr_en && addr == A_IRQ_STAT;
        stat_rd  = rd_en && addr == A_IRQ_STAT;
        hit_vec  = EVT_W'(hit) << EV_THR_BASE;
        evt_all  = evt_i | hit_vec;
        if (woc) clr_mask = stat_wr ? (wdata[EVT_W-1:0] | wdata[RAW_LSB +: EVT_W]) : '0;
        else     clr_mask = stat_rd ? '1 : '0;
    end

    pirq_status #(.N(EVT_W)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .evt_i(evt_all),
        .clr_mask(clr_mask),
        .en_set_we(wr_en && addr == A_EN_SET),
        .en_clr_we(wr_en && addr == A_EN_CLR),
        .en_wdata(wdata[EVT_W-1:0]),
        .steer_wdata(wdata[STEER_LSB +: 2]),
        .raw_o(raw_q),
        .en_o(en_q),
        .steer_o(steer_o)
    );

    // Purpose: gate the status and drive the interrupt and the control outputs.
    always_comb begin
        masked      = raw_q & en_q;
        irq_o       = |masked;
        port_rst_o  = ctrl_q[0];
        dev_rst_o   = ctrl_q[1];
        port_init_o = ctrl_q[2];
    end

    // Purpose: read mux.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL_SET: begin
                rdata[CTRL_W-1:0] = ctrl_q;
                rdata[READY_BIT]  = port_ready_i;
            end
            A_IRQ_STAT: begin
                rdata[EVT_W-1:0]         = masked;
                rdata[RAW_LSB +: EVT_W]  = raw_q;
            end
            A_EN_SET: begin
                rdata[EVT_W-1:0]         = en_q;
                rdata[STEER_LSB +: 2]    = steer_o;
            end
            default: begin
                for (int k = 0; k < NUM_CNT; k++) begin
                    if (addr == ADDR_W'(A_CNT_BASE + 2*k))     rdata[CNT_W-1:0] = cnt_q[k];
                    if (addr == ADDR_W'(A_CNT_BASE + 2*k + 1)) rdata[CNT_W-1:0] = thr_q[k];
                end
            end
        endcase
    end
endmodule

// File: rtl/port_irq_regs_chk.sv
// Checker: temporal properties of the port register block, bound to the top module.
module port_irq_regs_chk
    import pirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [EVT_W-1:0]  evt_i,
    input logic [EVT_W-1:0]  en_q,
    input logic              irq_o,
    input logic [1:0]        steer_o,
    input logic              port_rst_o
);
    AST_ENABLED_EVT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & en_q)) && !(wr_en && addr == A_EN_CLR) |=> irq_o); // R6

    AST_NO_IRQ_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o); // R6

    AST_CTRL_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL_SET && wdata[0]) |=> port_rst_o); // R2

    AST_CTRL_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL_CLR && wdata[0]) |=> !port_rst_o); // R2

    AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == A_CTRL_SET || addr == A_CTRL_CLR)) |=> $stable(port_rst_o)); // R2

    AST_STEER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == A_EN_SET || addr == A_EN_CLR)) |=> steer_o == $past(wdata[STEER_LSB +: 2])); // R4
endmodule

bind port_irq_regs port_irq_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .evt_i(evt_i), .en_q(en_q), .irq_o(irq_o), .steer_o(steer_o), .port_rst_o(port_rst_o)
);

// File: tb/port_irq_regs_test.sv
// Bench: a scoreboard. Read tasks queue the expected words; a monitor compares them at the falling edge.
module port_irq_regs_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [3:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic [11:0] evt_i = 0;
    logic [2:0]  link_err_i = 0;
    logic        port_ready_i = 0;
    logic        irq_o, port_rst_o, dev_rst_o, port_init_o;
    logic [1:0]  steer_o;

    int total = 0, bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    port_irq_regs uut (.*);

    // Monitor: pop one expectation per read cycle and compare.
    always @(negedge clk) begin
        if (rd_en) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (rdata !== e) begin
                bad++;
                $display("FAIL %s addr=%0d got=%h exp=%h", t, addr, rdata, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1 wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1 wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1 rd_en = 1; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1 rd_en = 0;
    endtask

    task automatic evt(input logic [11:0] m);
        @(posedge clk); #1 evt_i = m;
        @(posedge clk); #1 evt_i = 0;
    endtask

    task automatic lerr(input logic [2:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 link_err_i = m;
            @(posedge clk); #1 link_err_i = 0;
        end
    endtask

    task automatic pin(input logic got, input logic e, input string t);
        total++;
        if (got !== e) begin
            bad++;
            $display("FAIL %s got=%b exp=%b", t, got, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog got=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        pin(irq_o, 0, "R1 irq");
        pin(port_rst_o, 0, "R1 port_rst");
        rd(0, 32'h0, "R1 ctrl");
        rd(2, 32'h0, "R1 stat");
        rd(3, 32'h0, "R1 enable");
        rd(5, 32'h0, "R1 counter");
        rd(8, 32'h0, "R1 threshold");
        // R3 ready flag in bit 31
        port_ready_i = 1;
        rd(0, 32'h8000_0000, "R3 ready");
        // R2 set/clear
        wr(0, 32'h7);
        pin(port_rst_o, 1, "R2 port_rst set");
        pin(dev_rst_o, 1, "R2 dev_rst set");
        pin(port_init_o, 1, "R2 init set");
        wr(1, 32'h2);
        pin(dev_rst_o, 0, "R2 dev_rst clr");
        pin(port_rst_o, 1, "R2 port_rst kept");
        rd(0, 32'h8000_0005, "R2 R3 ctrl readback");
        wr(1, 32'h5);
        rd(0, 32'h8000_0000, "R2 all clear");
        // R4 enables and steering
        wr(3, 32'h4000_0003);
        rd(3, 32'h4000_0003, "R4 enable set");
        wr(4, 32'hC000_0001);
        rd(3, 32'hC000_0002, "R4 enable clr");
        pin(steer_o[1], 1, "R4 steer hi");
        pin(steer_o[0], 1, "R4 steer lo");
        // R5 R6 masked vs raw, read-to-clear mode (R8)
        evt(12'h001);
        pin(irq_o, 0, "R6 masked event no irq");
        rd(2, 32'h0001_0000, "R5 raw only");
        rd(2, 32'h0, "R8 read cleared");
        evt(12'h002);
        pin(irq_o, 1, "R6 enabled event irq");
        wr(2, 32'hFFFF_FFFF);
        pin(irq_o, 1, "R8 write ignored");
        rd(2, 32'h0002_0002, "R5 R8 masked and raw");
        pin(irq_o, 0, "R8 irq after read clear");
        // R7 write-one-to-clear mode
        wr(0, 32'h8);
        evt(12'h006);
        rd(2, 32'h0006_0002, "R7 stat");
        rd(2, 32'h0006_0002, "R7 read no clear");
        wr(2, 32'h0004_0000);
        rd(2, 32'h0002_0002, "R7 clear via raw half");
        wr(2, 32'h0000_0002);
        rd(2, 32'h0, "R7 clear via masked half");
        pin(irq_o, 0, "R7 irq dropped");
        // R11 event beats clear
        @(posedge clk); #1 wr_en = 1; addr = 2; wdata = 32'h1; evt_i = 12'h001;
        @(posedge clk); #1 wr_en = 0; evt_i = 0;
        rd(2, 32'h0001_0000, "R11 event wins");
        wr(2, 32'h1);
        // R9 counting and saturation, zero threshold silent (R10)
        lerr(3'b001, 3);
        rd(5, 32'd3, "R9 decode count");
        wr(5, 32'hFFFE);
        lerr(3'b001, 2);
        rd(5, 32'hFFFF, "R9 saturate");
        rd(2, 32'h0, "R10 zero threshold silent");
        // R10 CRC threshold
        wr(8, 32'd2);
        wr(3, 32'h0000_0200);
        lerr(3'b010, 1);
        pin(irq_o, 0, "R10 below threshold");
        lerr(3'b010, 1);
        pin(irq_o, 1, "R10 at threshold irq");
        rd(2, 32'h0200_0200, "R10 crc event");
        rd(7, 32'd2, "R9 crc count");
        lerr(3'b010, 1);
        wr(2, 32'h200);
        lerr(3'b010, 1);
        rd(2, 32'h0, "R10 no event past threshold");
        rd(8, 32'd2, "R10 threshold readback");
        // R10 handshake threshold, disabled event
        wr(10, 32'd1);
        lerr(3'b100, 1);
        rd(2, 32'h0400_0000, "R10 handshake raw");
        pin(irq_o, 0, "R6 R10 disabled threshold no irq");
        rd(9, 32'd1, "R9 handshake count");
        repeat (2) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule